// File: doc/BRIEF.md
# Stepped Digital Audio Attenuator

This block scales a signed 16-bit audio stream by an 8-bit gain coefficient. Each accepted sample is multiplied by the coefficient and divided by 256, which gives an output level of 20·log10(coefficient/256) dB. A coefficient of 00h is full silence, and that is the value the block holds after reset. Audio is heard only once the host writes a nonzero gain, typically EEh.

The host drives already-decoded commands. A direct-set command loads any coefficient at once. Four ramp commands move the gain one step per audio sample, either up toward EEh or down toward 00h, in steps of 4 or 8 codes. The gain stops at whichever limit it is heading for. A busy flag stays high while a ramp is still moving, so the host knows when it may issue its next command. A step command that arrives during a ramp is dropped. A direct set always wins and ends any ramp that is in progress.

Top module: `step_attenuator`

## Requirements
- R1: After synchronous reset the coefficient is 00h, `ramp_busy` is low and `out_valid` is low, so every sample comes out as 0.
- R2: For a sample accepted while `in_valid` is high, the output one cycle later is floor(sample × coefficient / 256), with the sample signed and the coefficient unsigned. `out_valid` is high in exactly that cycle and low one cycle after any cycle where `in_valid` is low.
- R3: A direct set (`cmd_valid` high with `cmd_op` = 1) loads `cmd_data` (any value 00h–FFh) as the coefficient and drops `ramp_busy` in the next cycle. This happens even while a ramp is in progress, which it cancels.
- R4: Up-step commands are `cmd_op` = 2 (step 4) and `cmd_op` = 4 (step 8). When accepted with the coefficient below EEh, they raise `ramp_busy` in the next cycle. Each later accepted sample then adds the step, clamped at EEh, and `ramp_busy` falls when EEh is reached. From 00h, this takes 60 samples with step 4 and 30 samples with step 8.
- R5: Down-step commands are `cmd_op` = 3 (step 4) and `cmd_op` = 5 (step 8). When accepted with a nonzero coefficient, they lower it by the step on each accepted sample, clamped at 00h, and `ramp_busy` falls when 00h is reached.
- R6: While a ramp is active, the coefficient changes only in cycles where `in_valid` is high, by one step per sample.
- R7: A step command issued while `ramp_busy` is high has no effect on the ramp. `cmd_op` values 0, 6 and 7 have no effect at all, and neither does any cycle with `cmd_valid` low.
- R8: An up-step command with the coefficient at or above EEh, or a down-step command with the coefficient at 00h, leaves the coefficient unchanged and `ramp_busy` low.
- R9: A sample is scaled by the coefficient held in the cycle it is accepted. A set or a ramp step in that same cycle takes effect from the next sample onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code (1 set, 2 up 4, 3 down 4, 4 up 8, 5 down 8) |
| cmd_data | input | 8 | Coefficient for a direct set |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Signed attenuated sample |
| ramp_busy | output | 1 | High while a ramp is still moving the coefficient |

## Verification
Any fault in the coefficient register shows at the port on the very next accepted sample. A sample of 256 is scaled to exactly the coefficient, so feeding that value makes the internal gain readable one cycle later. A fault in the ramp state shows in two ways: a step-by-step trace of those outputs that departs from the expected sequence, and `ramp_busy` falling after the wrong number of samples or at a value other than the limit. Both faults are visible within one sample period of the error.

// File: rtl/atten_pkg.sv
package atten_pkg;

    localparam int SAMPLE_W     = 16;
    localparam int COEF_W       = 8;
    localparam int OP_W         = 3;
    localparam logic [COEF_W-1:0] COEF_TOP = 8'hEE;
    localparam int STEP_FINE    = 4;
    localparam int STEP_COARSE  = 8;

    typedef enum logic [OP_W-1:0] {
        OP_NONE      = 3'd0,
        OP_SET       = 3'd1,
        OP_UP_FINE   = 3'd2,
        OP_DN_FINE   = 3'd3,
        OP_UP_COARSE = 3'd4,
        OP_DN_COARSE = 3'd5
    } att_op_e;

    typedef struct packed {
        logic active;
        logic up;
        logic coarse;
    } ramp_t;

    function automatic logic is_step_op(input logic [OP_W-1:0] op);
        return (op >= 3'd2) && (op <= 3'd5);
    endfunction

endpackage

// File: rtl/atten_coef.sv
module atten_coef
    import atten_pkg::*;
#(
    parameter int COEF_W = atten_pkg::COEF_W,
    parameter logic [COEF_W-1:0] TOP = atten_pkg::COEF_TOP,
    parameter int FINE   = atten_pkg::STEP_FINE,
    parameter int COARSE = atten_pkg::STEP_COARSE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [COEF_W-1:0] cmd_data,
    input  logic              sample_tick,
    output logic [COEF_W-1:0] coef,
    output logic              busy
);
    localparam int EW = COEF_W + 1;

    logic [COEF_W-1:0] coef_q;
    ramp_t             ramp_q;
    logic              set_cmd, step_cmd, req_up, req_coarse, can_start;
    logic [EW-1:0]     step_sz, up_sum;
    logic [COEF_W-1:0] up_next, dn_next, nxt, limit;

    assign set_cmd    = cmd_valid && (cmd_op == OP_SET);
    assign step_cmd   = cmd_valid && is_step_op(cmd_op) && !ramp_q.active;
    assign req_up     = (cmd_op == OP_UP_FINE) || (cmd_op == OP_UP_COARSE);
    assign req_coarse = (cmd_op == OP_UP_COARSE) || (cmd_op == OP_DN_COARSE);
    assign can_start  = req_up ? (coef_q < TOP) : (coef_q != '0);

    assign step_sz = ramp_q.coarse ? EW'(COARSE) : EW'(FINE);
    assign up_sum  = {1'b0, coef_q} + step_sz;
    assign up_next = (up_sum >= {1'b0, TOP}) ? TOP : up_sum[COEF_W-1:0];
    assign dn_next = ({1'b0, coef_q} <= step_sz) ? '0 : coef_q - step_sz[COEF_W-1:0];
    assign nxt     = ramp_q.up ? up_next : dn_next;
    assign limit   = ramp_q.up ? TOP : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            coef_q <= '0;
            ramp_q <= '0;
        end else if (set_cmd) begin
            coef_q        <= cmd_data;
            ramp_q.active <= 1'b0;
        end else if (step_cmd) begin
            ramp_q <= '{active: can_start, up: req_up, coarse: req_coarse};
        end else if (ramp_q.active && sample_tick) begin
            coef_q        <= nxt;
            ramp_q.active <= (nxt != limit);
        end
    end

    assign coef = coef_q;
    assign busy = ramp_q.active;

    // R6: without a set or a sample the coefficient holds
    assert_coef_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!set_cmd && !sample_tick) |=> $stable(coef_q));

    // R3: a direct set loads the data and stops any ramp
    assert_set_load_R3: assert property (@(posedge clk) disable iff (rst)
        set_cmd |=> (coef_q == $past(cmd_data)) && !ramp_q.active);

    // R4 / R5: a ramp that ends by itself ends at a limit
    assert_ramp_end_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(ramp_q.active) && !$past(set_cmd)) |-> (coef_q == '0 || coef_q == TOP));

    // R7: a step command during a ramp keeps the ramp running
    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        (ramp_q.active && cmd_valid && is_step_op(cmd_op) && !sample_tick) |=> ramp_q.active);

endmodule

// File: rtl/atten_mult.sv
module atten_mult
    import atten_pkg::*;
#(
    parameter int SAMPLE_W = atten_pkg::SAMPLE_W,
    parameter int COEF_W   = atten_pkg::COEF_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    input  logic [COEF_W-1:0]          coef,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_sample
);
    localparam int PW = SAMPLE_W + COEF_W + 1;

    logic signed [PW-1:0]       prod;
    logic signed [SAMPLE_W-1:0] scaled;

    assign prod   = PW'(in_sample) * $signed({1'b0, coef});
    assign scaled = prod[COEF_W +: SAMPLE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_sample <= scaled;
        end
    end

    // R2: one-cycle strobe latency
    assert_valid_lat_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R1: a zero coefficient silences the sample
    assert_mute_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && coef == '0) |=> (out_sample == '0));

endmodule

// File: rtl/step_attenuator.sv
module step_attenuator
    import atten_pkg::*;
#(
    parameter int SAMPLE_W = atten_pkg::SAMPLE_W,
    parameter int COEF_W   = atten_pkg::COEF_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [OP_W-1:0]     cmd_op,
    input  logic [COEF_W-1:0]   cmd_data,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                ramp_busy
);
    logic [COEF_W-1:0] coef;

    atten_coef #(.COEF_W(COEF_W)) u_coef (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_data    (cmd_data),
        .sample_tick (in_valid),
        .coef        (coef),
        .busy        (ramp_busy)
    );

    atten_mult #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)) u_mult (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .coef       (coef),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

endmodule

// File: tb/sim_step_attenuator.sv
module sim_step_attenuator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  cmd_data = 8'h00;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = 16'h0000;
    logic        out_valid;
    logic [15:0] out_sample;
    logic        ramp_busy;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    step_attenuator u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_sample(out_sample), .ramp_busy(ramp_busy)
    );

    // {coefficient, sample, expected output}
    localparam logic [39:0] VEC [10] = '{
        {8'hEE, 16'h7FFF, 16'h76FF},
        {8'hEE, 16'h8000, 16'h8900},
        {8'h80, 16'h0100, 16'h0080},
        {8'hFF, 16'h7FFF, 16'h7F7F},
        {8'hFF, 16'h8000, 16'h8080},
        {8'h01, 16'hFFFF, 16'hFFFF},
        {8'h00, 16'h7FFF, 16'h0000},
        {8'h01, 16'h00FF, 16'h0000},
        {8'h40, 16'hFF00, 16'hFFC0},
        {8'h10, 16'h1234, 16'h0123}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic send(input logic [15:0] s, output logic [15:0] o, output logic v);
        @(negedge clk);
        in_valid = 1'b1; in_sample = s;
        @(negedge clk);
        in_valid = 1'b0;
        o = out_sample; v = out_valid;
    endtask

    // runs an active ramp to its end, comparing every step against a model
    task automatic run_ramp(input int step, input logic up, input logic [7:0] start,
                            output int n, output logic [15:0] bad);
        logic [15:0] o;
        logic v;
        int e = start;
        n = 0; bad = 0;
        while (ramp_busy && n < 300) begin
            send(16'h0100, o, v);
            if (o !== 16'(e) || !v) bad++;
            e = up ? ((e + step > 238) ? 238 : e + step) : ((e < step) ? 0 : e - step);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] o;
        logic v;
        int n;
        logic [15:0] bad;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 out_valid after reset", {15'd0, out_valid}, 16'd0);
        check("R1 busy after reset", {15'd0, ramp_busy}, 16'd0);
        send(16'h7FFF, o, v);
        check("R1 muted output", o, 16'h0000);
        check("R2 out_valid follows in_valid", {15'd0, v}, 16'd1);
        @(negedge clk);
        check("R2 out_valid low when idle", {15'd0, out_valid}, 16'd0);

        // R2 table of gain / sample vectors
        for (int i = 0; i < 10; i++) begin
            cmd(3'd1, VEC[i][39:32]);
            send(VEC[i][31:16], o, v);
            check($sformatf("R2 vector %0d", i), o, VEC[i][15:0]);
        end

        // R4 fine up ramp from 0, with an ignored down command part way
        cmd(3'd1, 8'h00);
        cmd(3'd2, 8'h00);
        check("R4 busy after up4", {15'd0, ramp_busy}, 16'd1);
        // R6 no samples: coefficient holds
        repeat (20) @(negedge clk);
        check("R6 busy held without samples", {15'd0, ramp_busy}, 16'd1);
        for (int k = 0; k < 10; k++) begin
            send(16'h0100, o, v);
            check($sformatf("R6 step %0d value", k), o, 16'(4 * k));
        end
        cmd(3'd5, 8'h00);   // R7 ignored during busy
        check("R7 busy after ignored command", {15'd0, ramp_busy}, 16'd1);
        run_ramp(4, 1'b1, 8'd40, n, bad);
        check("R7 ramp trace unaffected", bad, 16'd0);
        check("R4 up4 total samples", 16'(n + 10), 16'd60);
        send(16'h0100, o, v);
        check("R4 up4 end value", o, 16'h00EE);

        // R4 coarse up ramp
        cmd(3'd1, 8'h00);
        cmd(3'd4, 8'h00);
        run_ramp(8, 1'b1, 8'd0, n, bad);
        check("R4 up8 trace", bad, 16'd0);
        check("R4 up8 samples", 16'(n), 16'd30);

        // R4 clamp from EC
        cmd(3'd1, 8'hEC);
        cmd(3'd2, 8'h00);
        run_ramp(4, 1'b1, 8'hEC, n, bad);
        check("R4 clamp samples", 16'(n), 16'd1);
        send(16'h0100, o, v);
        check("R4 clamp value", o, 16'h00EE);

        // R5 down ramps
        cmd(3'd3, 8'h00);
        check("R5 busy after down4", {15'd0, ramp_busy}, 16'd1);
        run_ramp(4, 1'b0, 8'hEE, n, bad);
        check("R5 down4 trace", bad, 16'd0);
        check("R5 down4 samples", 16'(n), 16'd60);
        cmd(3'd1, 8'h15);
        cmd(3'd5, 8'h00);
        run_ramp(8, 1'b0, 8'h15, n, bad);
        check("R5 down8 samples", 16'(n), 16'd3);
        send(16'h0100, o, v);
        check("R5 down8 floor", o, 16'h0000);

        // R8 steps already at limits
        cmd(3'd3, 8'h00);
        check("R8 down at zero not busy", {15'd0, ramp_busy}, 16'd0);
        cmd(3'd1, 8'hFF);
        cmd(3'd4, 8'h00);
        check("R8 up above top not busy", {15'd0, ramp_busy}, 16'd0);
        send(16'h0100, o, v);
        check("R8 coefficient unchanged", o, 16'h00FF);

        // R3 set cancels a ramp
        cmd(3'd1, 8'h00);
        cmd(3'd4, 8'h00);
        repeat (3) send(16'h0100, o, v);
        cmd(3'd1, 8'h50);
        check("R3 busy cleared by set", {15'd0, ramp_busy}, 16'd0);
        send(16'h0100, o, v);
        check("R3 set value", o, 16'h0050);
        send(16'h0100, o, v);
        check("R3 no further ramp", o, 16'h0050);

        // R7 unused codes and idle fields
        cmd(3'd1, 8'h30);
        cmd(3'd6, 8'hAA);
        cmd(3'd7, 8'hBB);
        cmd(3'd0, 8'hCC);
        @(negedge clk);
        cmd_op = 3'd1; cmd_data = 8'h99;   // cmd_valid low
        @(negedge clk);
        cmd_op = 3'd0;
        check("R7 busy after unused codes", {15'd0, ramp_busy}, 16'd0);
        send(16'h0100, o, v);
        check("R7 coefficient unchanged", o, 16'h0030);

        // R9 set in the same cycle as a sample
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_data = 8'h90;
        in_valid = 1'b1; in_sample = 16'h0100;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; in_valid = 1'b0;
        check("R9 same-cycle sample uses old gain", out_sample, 16'h0030);
        send(16'h0100, o, v);
        check("R9 next sample uses new gain", o, 16'h0090);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule